// File: doc/BRIEF.md
# Flash Boot Image Selector

This block runs once after reset and decides which firmware image a downstream loader should fetch from an attached serial flash. It drives an SPI master that only ever issues the plain read command, so any serial flash part can serve as the boot source. The block reads a one-sector table of small append-only records and takes the first valid record it finds as the newest header. That header names a primary and a secondary image. The block offers the loader the primary image first, then the secondary, and last a fallback image at a fixed flash offset.

The loader answers each offer with a pass or fail verdict from its own content checker. A strap input, taken from the flash clock pin's pull-up at reset, chooses between starting at once and first leaving a host window open. During that window a serial host may claim the device instead of the flash. The final outcome stays on the selection outputs until the next reset.

Top module: `flash_boot_sel`

## Requirements
- R1: Every flash access pulls `spiCsN` low, shifts out the byte 0x03 and then a 24-bit address, most significant bit first, and then reads 20 data bytes. SPI mode 0 is used: SCK idles low, MOSI changes only after a falling edge, and MISO is sampled on the rising edge. SCK stays high for exactly `CLK_DIV` clock cycles and low for exactly `CLK_DIV` clock cycles.
- R2: The header sector holds 16 records, each 256 bytes apart. Record n starts at `HDR_BASE + n*256`. Records are read in increasing n, starting at n = 0.
- R3: Record byte layout, all fields little-endian 32-bit words: bytes 0-3 primary offset, bytes 4-7 primary length, bytes 8-11 secondary offset, bytes 12-15 secondary length, bytes 16-19 checksum. Offsets and lengths are reported as their low 24 bits.
- R4: A record whose bytes 0-3 all read 0xFF is blank and is skipped.
- R5: A record is valid only if the checksum equals the CRC-32 of bytes 0-15. The CRC-32 uses the reflected polynomial 0xEDB88320, an all-ones initial value, bytes processed least significant bit first, and a final inversion. A record that fails this test is skipped.
- R6: The first valid record ends the scan. No further flash access follows it.
- R7: With a valid header, the primary image is offered first with `selSource` = 0. A fail verdict on it moves the offer to the secondary image with `selSource` = 1.
- R8: The fallback image (`FALLBACK_OFF`, `FALLBACK_LEN`, `selSource` = 2) is offered when the secondary fails, or when all 16 records are blank or invalid.
- R9: A fail verdict on the fallback leaves `selValid` = 1, `selSource` = 3, and offset and length both 0. This state is final.
- R10: A pass verdict freezes the current offer. Any later verdict is ignored.
- R11: With `sckStrap` high at reset, the first flash access starts within 4 cycles. With it low, there is no flash access for `HOST_WAIT` cycles. If `hostReq` is seen in that window, the block ends with `selSource` = 3 and never touches the flash.
- R12: `selValid` drops for exactly one cycle between two successive offers. Verdicts arriving while `selValid` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckStrap | input | 1 | Level of the flash clock pin pull-up, sampled at reset |
| hostReq | input | 1 | A serial host has claimed the device |
| spiSck | output | 1 | Flash serial clock |
| spiCsN | output | 1 | Flash chip select, active low |
| spiMosi | output | 1 | Command and address to the flash |
| spiMiso | input | 1 | Data from the flash |
| imgOk | input | 1 | Loader verdict: offered image passed |
| imgBad | input | 1 | Loader verdict: offered image failed |
| selValid | output | 1 | An offer or a final result is on the selection outputs |
| selOffset | output | 24 | Flash offset of the offered image |
| selLength | output | 24 | Length of the offered image |
| selSource | output | 2 | 0 primary, 1 secondary, 2 fallback, 3 none |

## Verification
The assertions assume three things about the environment. Verdicts are single-cycle pulses. `imgOk` and `imgBad` are never raised together. The flash drives MISO only after a falling SCK edge. The bench meets these assumptions in two ways. Its flash model changes MISO only on the falling edge of SCK. Every verdict is raised at a falling clock edge and cleared at the next one. The host-window and ignored-verdict cases drive pulses only while the block is idle or waiting, so they test the block's own rule that such pulses are ignored.

// File: rtl/flash_boot_sel_pkg.sv
package flash_boot_sel_pkg;

  typedef enum logic [2:0] {
    S_STRAP, S_WAIT, S_READ, S_BUSY, S_PRESENT, S_GAP, S_DONE
  } ctrlState_t;

  localparam logic [1:0] SRC_PRI  = 2'd0;
  localparam logic [1:0] SRC_SEC  = 2'd1;
  localparam logic [1:0] SRC_FALL = 2'd2;
  localparam logic [1:0] SRC_NONE = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic        start;
    logic [23:0] addr;
  } rdCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic        done;
    logic        busy;
    logic        blank;
    logic        crcOk;
    logic [23:0] priOff;
    logic [23:0] priLen;
    logic [23:0] secOff;
    logic [23:0] secLen;
  } rdStat_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] b);
    logic [31:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/flash_boot_sel_dp.sv
module flash_boot_sel_dp
  import flash_boot_sel_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  rdCmd_t  cmd,
  output rdStat_t stat,
  output logic    spiSck,
  output logic    spiCsN,
  output logic    spiMosi,
  input  logic    spiMiso
);

  localparam int CMD_BITS   = 32;
  localparam int REC_BYTES  = 20;
  localparam int TOTAL_BITS = CMD_BITS + 8 * REC_BYTES;
  localparam int DIV_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W      = $clog2(TOTAL_BITS);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [31:0]      txShift;
  logic [6:0]       rxShift;
  logic             busy, done;
  logic [31:0]      word0, crcRx, crcAcc;
  logic [23:0]      word1, word2, word3;

  logic [7:0] newByte;
  logic [4:0] byteIdx;
  logic [2:0] wordIdx;
  logic [1:0] laneIdx;
  logic       byteDone;

  assign newByte  = {rxShift, spiMiso};
  assign byteIdx  = bitCnt[BIT_W-1:3] - 5'd4;
  assign wordIdx  = byteIdx[4:2];
  assign laneIdx  = byteIdx[1:0];
  assign byteDone = (bitCnt >= BIT_W'(CMD_BITS)) && (bitCnt[2:0] == 3'd7);
  assign spiMosi  = txShift[31];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; spiCsN <= 1'b1; spiSck <= 1'b0;
      divCnt <= '0; bitCnt <= '0; txShift <= '0; rxShift <= '0;
      word0 <= '0; word1 <= '0; word2 <= '0; word3 <= '0;
      crcRx <= '0; crcAcc <= '1;
    end else begin
      done <= 1'b0;
      if (cmd.start && !busy) begin
        busy <= 1'b1; spiCsN <= 1'b0; spiSck <= 1'b0;
        divCnt <= '0; bitCnt <= '0;
        txShift <= {8'h03, cmd.addr};
        crcAcc <= '1;
      end else if (busy) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!spiSck) begin
            spiSck  <= 1'b1;
            rxShift <= newByte[6:0];
            if (byteDone) begin
              if (!byteIdx[4]) crcAcc <= crcStep(crcAcc, newByte);
              case (wordIdx)
                3'd0: word0[{laneIdx, 3'b000} +: 8] <= newByte;
                3'd1: if (laneIdx != 2'd3) word1[{laneIdx, 3'b000} +: 8] <= newByte;
                3'd2: if (laneIdx != 2'd3) word2[{laneIdx, 3'b000} +: 8] <= newByte;
                3'd3: if (laneIdx != 2'd3) word3[{laneIdx, 3'b000} +: 8] <= newByte;
                default: crcRx[{laneIdx, 3'b000} +: 8] <= newByte;
              endcase
            end
          end else begin
            spiSck  <= 1'b0;
            txShift <= {txShift[30:0], 1'b0};
            if (bitCnt == BIT_W'(TOTAL_BITS - 1)) begin
              busy <= 1'b0; spiCsN <= 1'b1; done <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign stat.done   = done;
  assign stat.busy   = busy;
  assign stat.blank  = (word0 == 32'hFFFF_FFFF);
  assign stat.crcOk  = (~crcAcc == crcRx);
  assign stat.priOff = word0[23:0];
  assign stat.priLen = word1;
  assign stat.secOff = word2;
  assign stat.secLen = word3;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);                                               // R1
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> $stable(spiMosi));                               // R1
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> $past(bitCnt) == BIT_W'(TOTAL_BITS - 1));        // R1

endmodule

// File: rtl/flash_boot_sel_ctrl.sv
module flash_boot_sel_ctrl
  import flash_boot_sel_pkg::*;
#(
  parameter int          HOST_WAIT    = 2_000_000,
  parameter int          REC_COUNT    = 16,
  parameter logic [23:0] HDR_BASE     = 24'h000000,
  parameter logic [23:0] FALLBACK_OFF = 24'hFF0000,
  parameter logic [23:0] FALLBACK_LEN = 24'h010000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckStrap,
  input  logic        hostReq,
  input  logic        imgOk,
  input  logic        imgBad,
  input  rdStat_t     stat,
  output rdCmd_t      cmd,
  output logic        selValid,
  output logic [23:0] selOffset,
  output logic [23:0] selLength,
  output logic [1:0]  selSource
);

  localparam int PAGE_SHIFT = 8;
  localparam int IDX_W      = (REC_COUNT > 1) ? $clog2(REC_COUNT) : 1;
  localparam int WAIT_W     = (HOST_WAIT > 1) ? $clog2(HOST_WAIT) : 1;

  ctrlState_t       state;
  logic [IDX_W-1:0] recIdx;
  logic [WAIT_W-1:0] waitCnt;

  assign cmd.start = (state == S_READ);
  assign cmd.addr  = HDR_BASE + (24'(recIdx) << PAGE_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_STRAP; recIdx <= '0; waitCnt <= '0;
      selValid <= 1'b0; selOffset <= '0; selLength <= '0; selSource <= SRC_PRI;
    end else begin
      case (state)
        S_STRAP: state <= sckStrap ? S_READ : S_WAIT;
        S_WAIT: begin
          if (hostReq) begin
            selValid <= 1'b1; selSource <= SRC_NONE;
            selOffset <= '0; selLength <= '0;
            state <= S_DONE;
          end else if (waitCnt == WAIT_W'(HOST_WAIT - 1)) begin
            state <= S_READ;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_READ: state <= S_BUSY;
        S_BUSY: begin
          if (stat.done) begin
            if (!stat.blank && stat.crcOk) begin
              selValid <= 1'b1; selSource <= SRC_PRI;
              selOffset <= stat.priOff; selLength <= stat.priLen;
              state <= S_PRESENT;
            end else if (recIdx == IDX_W'(REC_COUNT - 1)) begin
              selValid <= 1'b1; selSource <= SRC_FALL;
              selOffset <= FALLBACK_OFF; selLength <= FALLBACK_LEN;
              state <= S_PRESENT;
            end else begin
              recIdx <= recIdx + 1'b1;
              state <= S_READ;
            end
          end
        end
        S_PRESENT: begin
          if (imgOk) begin
            state <= S_DONE;
          end else if (imgBad) begin
            case (selSource)
              SRC_PRI: begin
                selValid <= 1'b0; selSource <= SRC_SEC;
                selOffset <= stat.secOff; selLength <= stat.secLen;
                state <= S_GAP;
              end
              SRC_SEC: begin
                selValid <= 1'b0; selSource <= SRC_FALL;
                selOffset <= FALLBACK_OFF; selLength <= FALLBACK_LEN;
                state <= S_GAP;
              end
              default: begin
                selSource <= SRC_NONE; selOffset <= '0; selLength <= '0;
                state <= S_DONE;
              end
            endcase
          end
        end
        S_GAP: begin
          selValid <= 1'b1;
          state <= S_PRESENT;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  AST_NONE_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && selSource == SRC_NONE) |=> (selValid && selSource == SRC_NONE)); // R9
  AST_QUIET_WHILE_OFFERING: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> !stat.busy);                                                    // R6
  AST_QUIET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !stat.busy);                                           // R11
  AST_GAP_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PRESENT && imgBad && !imgOk && selSource != SRC_FALL) |=> !selValid); // R12

endmodule

// File: rtl/flash_boot_sel.sv
module flash_boot_sel
  import flash_boot_sel_pkg::*;
#(
  parameter int          CLK_DIV      = 2,
  parameter int          HOST_WAIT    = 2_000_000,
  parameter logic [23:0] HDR_BASE     = 24'h000000,
  parameter logic [23:0] FALLBACK_OFF = 24'hFF0000,
  parameter logic [23:0] FALLBACK_LEN = 24'h010000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckStrap,
  input  logic        hostReq,
  output logic        spiSck,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso,
  input  logic        imgOk,
  input  logic        imgBad,
  output logic        selValid,
  output logic [23:0] selOffset,
  output logic [23:0] selLength,
  output logic [1:0]  selSource
);

  rdCmd_t  rdCmd;
  rdStat_t rdStat;

  flash_boot_sel_ctrl #(
    .HOST_WAIT(HOST_WAIT), .REC_COUNT(16), .HDR_BASE(HDR_BASE),
    .FALLBACK_OFF(FALLBACK_OFF), .FALLBACK_LEN(FALLBACK_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sckStrap(sckStrap), .hostReq(hostReq),
    .imgOk(imgOk), .imgBad(imgBad), .stat(rdStat), .cmd(rdCmd),
    .selValid(selValid), .selOffset(selOffset), .selLength(selLength),
    .selSource(selSource)
  );

  flash_boot_sel_dp #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(rdCmd), .stat(rdStat),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

endmodule

// File: tb/flash_boot_sel_bench.sv
module flash_boot_sel_bench;

  localparam int          DIV  = 2;
  localparam int          HW   = 200;
  localparam logic [23:0] FOFF = 24'hFF0000;
  localparam logic [23:0] FLEN = 24'h001000;

  logic clk = 1'b0, rstN = 1'b0, sckStrap = 1'b0, hostReq = 1'b0;
  logic imgOk = 1'b0, imgBad = 1'b0;
  logic spiSck, spiCsN, spiMosi, spiMiso;
  logic selValid;
  logic [23:0] selOffset, selLength;
  logic [1:0] selSource;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_boot_sel #(.CLK_DIV(DIV), .HOST_WAIT(HW), .HDR_BASE(24'h0),
                   .FALLBACK_OFF(FOFF), .FALLBACK_LEN(FLEN)) u_flash_boot_sel (
    .clk(clk), .rstN(rstN), .sckStrap(sckStrap), .hostReq(hostReq),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .imgOk(imgOk), .imgBad(imgBad), .selValid(selValid), .selOffset(selOffset),
    .selLength(selLength), .selSource(selSource));

  // ---------------- flash model ----------------
  logic [7:0]  recMem [0:319];
  logic [31:0] cmdReg = 32'h0300_0000;
  logic [23:0] lastAddr = '0;
  logic        misoR = 1'b0;
  int bitCount = 0, txnCount = 0, badOps = 0;

  assign spiMiso = misoR;

  function automatic logic [7:0] byteAt(input logic [23:0] a);
    if (a[23:12] == 12'h0 && a[7:0] < 8'd20) return recMem[int'(a[11:8]) * 20 + int'(a[7:0])];
    return 8'hFF;
  endfunction

  always @(negedge spiCsN) begin bitCount = 0; txnCount++; end
  always @(posedge spiSck) if (!spiCsN) begin
    if (bitCount < 32) cmdReg = {cmdReg[30:0], spiMosi};
    bitCount++;
  end
  always @(posedge spiCsN) begin
    lastAddr = cmdReg[23:0];
    if (cmdReg[31:24] != 8'h03) badOps++;
  end
  always @(negedge spiSck) if (!spiCsN && bitCount >= 32) begin
    int rel;
    logic [7:0] b;
    rel = bitCount - 32;
    b = byteAt(cmdReg[23:0] + 24'(rel / 8));
    misoR = b[7 - rel % 8];
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] crcOf(input logic [127:0] data);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 128; k++) begin
      logic bitIn;
      bitIn = data[k];
      c = (c[0] ^ bitIn) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic clearRecs();
    for (int i = 0; i < 320; i++) recMem[i] = 8'hFF;
  endtask

  task automatic setRec(input int idx, input logic [31:0] po, input logic [31:0] pl,
                        input logic [31:0] so, input logic [31:0] sl, input bit corrupt);
    logic [127:0] d;
    logic [31:0] c;
    d = {sl, so, pl, po};
    c = crcOf(d) ^ (corrupt ? 32'h1 : 32'h0);
    for (int i = 0; i < 16; i++) recMem[idx*20 + i] = d[i*8 +: 8];
    for (int i = 0; i < 4; i++) recMem[idx*20 + 16 + i] = c[i*8 +: 8];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resetDut(input bit strap);
    @(negedge clk);
    rstN = 1'b0; sckStrap = strap; hostReq = 1'b0; imgOk = 1'b0; imgBad = 1'b0;
    repeat (3) @(negedge clk);
    txnCount = 0; badOps = 0; cmdReg = 32'h0300_0000;
    rstN = 1'b1;
  endtask

  task automatic waitSel(input string req);
    int n = 0;
    while (!selValid && n < 20000) begin @(negedge clk); n++; end
    chk({req, " offer seen"}, 32'(selValid), 32'd1);
  endtask

  task automatic verdict(input bit ok);
    if (ok) imgOk = 1'b1; else imgBad = 1'b1;
    @(negedge clk);
    imgOk = 1'b0; imgBad = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    resetDut(1'b1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 reset selValid", 32'(selValid), 32'd0);
    chk("R1 reset csN high", 32'(spiCsN), 32'd1);
    chk("R1 reset sck low", 32'(spiSck), 32'd0);
  endtask

  task automatic tPrimaryPass();
    int n = 0;
    clearRecs();
    setRec(0, 32'h0001_0000, 32'h0000_2000, 32'h0004_0000, 32'h0000_3000, 0);
    resetDut(1'b1);
    while (spiCsN && n < 50) begin @(posedge clk); n++; #1; end
    checks++;
    if (n > 4) begin errors++; $display("FAIL R11 strap start actual=%0d expected<=4", n); end
    @(posedge spiSck);
    n = 0;
    do begin @(posedge clk); n++; #1; end while (spiSck);
    chk("R1 sck high width", 32'(n), 32'(DIV));
    n = 0;
    do begin @(posedge clk); n++; #1; end while (!spiSck);
    chk("R1 sck low width", 32'(n), 32'(DIV));
    waitSel("R7");
    chk("R7 primary source", 32'(selSource), 32'd0);
    chk("R3 primary offset", 32'(selOffset), 32'h01_0000);
    chk("R3 primary length", 32'(selLength), 32'h00_2000);
    chk("R6 one read", 32'(txnCount), 32'd1);
    chk("R1 opcode", 32'(badOps), 32'd0);
    chk("R2 first record addr", 32'(lastAddr), 32'h0);
    verdict(1'b1);
    repeat (3) @(negedge clk);
    verdict(1'b0);
    repeat (3) @(negedge clk);
    chk("R10 frozen source", 32'(selSource), 32'd0);
    chk("R10 frozen valid", 32'(selValid), 32'd1);
  endtask

  task automatic tChain();
    clearRecs();
    recMem[0] = 8'hFF;                  // record 0 blank
    setRec(1, 32'h11, 32'h22, 32'h33, 32'h44, 1);
    setRec(2, 32'h0002_0000, 32'h0000_0100, 32'h0030_0000, 32'h0000_0200, 0);
    setRec(3, 32'h0005_0000, 32'h0000_0500, 32'h0006_0000, 32'h0000_0600, 0);
    resetDut(1'b1);
    waitSel("R5");
    chk("R4 R5 skip to record 2", 32'(selOffset), 32'h02_0000);
    chk("R6 three reads", 32'(txnCount), 32'd3);
    chk("R2 record 2 addr", 32'(lastAddr), 32'h000200);
    verdict(1'b0);
    chk("R12 gap low", 32'(selValid), 32'd0);
    @(negedge clk);
    chk("R12 gap one cycle", 32'(selValid), 32'd1);
    chk("R7 secondary source", 32'(selSource), 32'd1);
    chk("R7 secondary offset", 32'(selOffset), 32'h30_0000);
    chk("R7 secondary length", 32'(selLength), 32'h00_0200);
    verdict(1'b0);
    @(negedge clk);
    chk("R8 fallback source", 32'(selSource), 32'd2);
    chk("R8 fallback offset", 32'(selOffset), 32'(FOFF));
    chk("R8 fallback length", 32'(selLength), 32'(FLEN));
    verdict(1'b0);
    repeat (2) @(negedge clk);
    chk("R9 none source", 32'(selSource), 32'd3);
    chk("R9 none valid", 32'(selValid), 32'd1);
    chk("R9 none offset", 32'(selOffset), 32'd0);
    chk("R9 none length", 32'(selLength), 32'd0);
    verdict(1'b1);
    chk("R9 stays none", 32'(selSource), 32'd3);
  endtask

  task automatic tAllBlank();
    clearRecs();
    resetDut(1'b1);
    waitSel("R8");
    chk("R8 no header fallback", 32'(selSource), 32'd2);
    chk("R2 sixteen reads", 32'(txnCount), 32'd16);
    chk("R2 last record addr", 32'(lastAddr), 32'h000F00);
  endtask

  task automatic tHostWindow();
    int n = 0;
    clearRecs();
    setRec(0, 32'h0007_0000, 32'h10, 32'h0008_0000, 32'h20, 0);
    resetDut(1'b0);
    repeat (20) @(negedge clk);
    verdict(1'b0);                      // ignored: nothing on offer
    n = 21;
    while (spiCsN && n < HW + 50) begin @(posedge clk); n++; #1; end
    checks++;
    if (n < HW || n > HW + 4) begin
      errors++; $display("FAIL R11 window actual=%0d expected=%0d..%0d", n, HW, HW + 4);
    end
    waitSel("R12");
    chk("R12 early verdict ignored", 32'(selSource), 32'd0);
    chk("R12 offset after window", 32'(selOffset), 32'h07_0000);
  endtask

  task automatic tHostClaim();
    clearRecs();
    setRec(0, 32'h0007_0000, 32'h10, 32'h0008_0000, 32'h20, 0);
    resetDut(1'b0);
    repeat (50) @(negedge clk);
    hostReq = 1'b1;
    @(negedge clk);
    hostReq = 1'b0;
    repeat (HW + 20) @(negedge clk);
    chk("R11 host claim valid", 32'(selValid), 32'd1);
    chk("R11 host claim source", 32'(selSource), 32'd3);
    chk("R11 host claim no reads", 32'(txnCount), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clearRecs();
    tReset();
    tPrimaryPass();
    tChain();
    tAllBlank();
    tHostWindow();
    tHostClaim();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule